// File: doc/BRIEF.md
# Reset Cause Flag Register

This block keeps a record of why the chip is in, or has just left, reset. Five sticky flags cover power-on, long hardware, short hardware, software and watchdog resets. Each cycle the reset sequencer may report one classified reset event. A power-on detect input promotes a hardware event to a power-on event. The block also takes an end-of-initialisation strobe, which closes the start-up phase, and a watchdog-service strobe. Start-up software reads the flags on a register read port to find out which reset path brought it there.

The four start-up flags are cumulative: a more severe reset also sets the flags of every milder one. They therefore form a thermometer code, which is held as a severity state machine. The states are `SEV_NONE`, `SEV_SW`, `SEV_SHORT`, `SEV_LONG` and `SEV_POR`.
- A reset event more severe than the current state raises the state to that event's level.
- A milder event holds the current state.
- End-of-init drops the state to `SEV_NONE`.
- When end-of-init and a reset event arrive in the same cycle, the state goes to the new event's own level.

Because of the raise rule, a software or short reset that the sequencer then escalates to a long reset ends in `SEV_LONG`.

The watchdog flag is separate and has its own clear events. The same register word carries a writable watchdog prescale select bit and a reload field for the external watchdog counter.

Top module: `rcf_flag_reg`

## Requirements
- R1: After `arst_n` is asserted, `reg_rdata` is 0 and `wdt_div` is 2.
- R2: A software event (`evt_valid`=1, `evt_kind`=0) sets the software flag, which is bit 2 of `reg_rdata`. It changes no other flag, and the flag is visible after the clock edge that samples the event.
- R3: A short hardware event (`evt_kind`=2) sets bits 3 and 2 (short, software). A long hardware event (`evt_kind`=3) sets bits 4, 3 and 2. Either kind with `por_det`=1 sets bits 5 to 2 (power-on, long, short, software).
- R4: The start-up flags accumulate. A milder event never clears a flag that a more severe event set, and a software or short event followed by a long event shows bits 4 to 2 set.
- R5: `eoi` clears bits 5 to 2 on the next edge and leaves bit 1 unchanged. If a reset event arrives in the same cycle as `eoi`, bits 5 to 2 show exactly that event's set.
- R6: A watchdog event (`evt_kind`=1) sets bit 1 only. `wdt_svc`, or a short or long hardware event, clears bit 1. A watchdog event in the same cycle as `wdt_svc` leaves bit 1 set. `eoi` has no effect on bit 1.
- R7: A write (`reg_wr`=1) stores `reg_wdata[0]` as the prescale select and `reg_wdata[15:8]` as the reload value. Written values in bits 7 to 1 are ignored, and those bits read back as the flags (bits 7 and 6 read 0).
- R8: `wdt_div` is 2 when bit 0 is 0 and 128 when bit 0 is 1. `wdt_reload` equals bits 15 to 8.
- R9: Any reset event of kind 0 to 3 returns bit 0 and bits 15 to 8 to zero on the next edge. This holds even when a write arrives in the same cycle.
- R10: An event with `evt_kind` 4 to 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous initialisation of the register itself, active low |
| evt_valid | input | 1 | One-cycle pulse: a classified reset event is present |
| evt_kind | input | 3 | Event kind: 0 software, 1 watchdog, 2 short hardware, 3 long hardware |
| por_det | input | 1 | Power-on condition detected; promotes a hardware event to power-on |
| eoi | input | 1 | End-of-initialisation strobe |
| wdt_svc | input | 1 | Watchdog-service strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data: {reload, 2'b0, por, long, short, sw, wdt, prescale select} |
| wdt_reload | output | 8 | Reload value for the watchdog counter |
| wdt_div | output | 8 | Watchdog input divide ratio |

## Verification
A corrupted severity state shows at once on `reg_rdata` as flag bits 5 to 2 that are either not a thermometer code or disagree with the most severe event since the last end-of-init. The error is visible one edge after the event or strobe that caused it. A wrong watchdog flag shows on bit 1 on the edge after a watchdog event, a service strobe or a hardware event. A wrong stored prescale select shows on `wdt_div` in the same cycle that bit 0 changes. The bench compares every cycle against a reference model, so no such error stays hidden past the next sample.

// File: rtl/rcf_pkg.sv
package rcf_pkg;

    // Event kind codes supplied by the reset sequencer.
    localparam logic [2:0] KIND_SW    = 3'd0;
    localparam logic [2:0] KIND_WDT   = 3'd1;
    localparam logic [2:0] KIND_SHORT = 3'd2;
    localparam logic [2:0] KIND_LONG  = 3'd3;

    // Severity since the last end-of-init; the flags are a thermometer of it.
    typedef enum logic [2:0] {
        SEV_NONE  = 3'd0,
        SEV_SW    = 3'd1,
        SEV_SHORT = 3'd2,
        SEV_LONG  = 3'd3,
        SEV_POR   = 3'd4
    } sev_t;

    // Read word layout.
    localparam int BIT_FSEL   = 0;
    localparam int BIT_WDT    = 1;
    localparam int BIT_SW     = 2;
    localparam int BIT_SHORT  = 3;
    localparam int BIT_LONG   = 4;
    localparam int BIT_POR    = 5;
    localparam int RELOAD_LSB = 8;

    function automatic logic is_hw_kind(input logic [2:0] kind);
        return (kind == KIND_SHORT) || (kind == KIND_LONG);
    endfunction

    function automatic logic is_known_kind(input logic [2:0] kind);
        return kind <= KIND_LONG;
    endfunction

endpackage

// File: rtl/rcf_cause_fsm.sv
module rcf_cause_fsm
    import rcf_pkg::*;
(
    input  logic       clk,
    input  logic       arst_n,
    input  logic       evt_valid,
    input  logic [2:0] evt_kind,
    input  logic       por_det,
    input  logic       eoi,
    output logic [3:0] cause_flags   // {por, long, short, sw}
);

    sev_t state_q;
    sev_t state_d;
    sev_t ev_sev;
    sev_t base_sev;

    // Severity carried by the incoming event (R2, R3, R10).
    always_comb begin
        ev_sev = SEV_NONE;
        if (evt_valid) begin
            unique case (evt_kind)
                KIND_SW:    ev_sev = SEV_SW;
                KIND_SHORT: ev_sev = por_det ? SEV_POR : SEV_SHORT;
                KIND_LONG:  ev_sev = por_det ? SEV_POR : SEV_LONG;
                default:    ev_sev = SEV_NONE;
            endcase
        end
    end

    // Transitions: raise on a more severe event, hold otherwise; eoi drops to
    // SEV_NONE, but an event in the same cycle still lands (R4, R5).
    always_comb begin
        base_sev = eoi ? SEV_NONE : state_q;
        state_d  = (ev_sev > base_sev) ? ev_sev : base_sev;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            state_q <= SEV_NONE;
        end else begin
            state_q <= state_d;
        end
    end

    // Output decode.
    always_comb begin
        unique case (state_q)
            SEV_NONE:  cause_flags = 4'b0000;
            SEV_SW:    cause_flags = 4'b0001;
            SEV_SHORT: cause_flags = 4'b0011;
            SEV_LONG:  cause_flags = 4'b0111;
            SEV_POR:   cause_flags = 4'b1111;
            default:   cause_flags = 4'b0000;
        endcase
    end

endmodule

// File: rtl/rcf_wdt_flag.sv
module rcf_wdt_flag
    import rcf_pkg::*;
(
    input  logic       clk,
    input  logic       arst_n,
    input  logic       evt_valid,
    input  logic [2:0] evt_kind,
    input  logic       wdt_svc,
    output logic       wdt_flag
);

    logic set_wdt;
    logic clr_wdt;

    // R6: set beats clear; eoi is not an input here.
    assign set_wdt = evt_valid && (evt_kind == KIND_WDT);
    assign clr_wdt = wdt_svc || (evt_valid && is_hw_kind(evt_kind));

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            wdt_flag <= 1'b0;
        end else if (set_wdt) begin
            wdt_flag <= 1'b1;
        end else if (clr_wdt) begin
            wdt_flag <= 1'b0;
        end
    end

endmodule

// File: rtl/rcf_cfg_reg.sv
module rcf_cfg_reg #(
    parameter int RELOAD_W = 8,
    parameter int DIV_LO   = 2,
    parameter int DIV_HI   = 128,
    localparam int DIV_W   = $clog2(DIV_HI + 1)
) (
    input  logic                clk,
    input  logic                arst_n,
    input  logic                any_evt,
    input  logic                wr,
    input  logic                wr_fsel,
    input  logic [RELOAD_W-1:0] wr_reload,
    output logic                fsel,
    output logic [RELOAD_W-1:0] reload,
    output logic [DIV_W-1:0]    div_ratio
);

    // R7, R9: a reset event wins over a write in the same cycle.
    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) begin
            fsel   <= 1'b0;
            reload <= '0;
        end else if (any_evt) begin
            fsel   <= 1'b0;
            reload <= '0;
        end else if (wr) begin
            fsel   <= wr_fsel;
            reload <= wr_reload;
        end
    end

    // R8
    assign div_ratio = fsel ? DIV_W'(DIV_HI) : DIV_W'(DIV_LO);

endmodule

// File: rtl/rcf_flag_reg.sv
module rcf_flag_reg
    import rcf_pkg::*;
#(
    parameter int RELOAD_W = 8,
    parameter int DIV_LO   = 2,
    parameter int DIV_HI   = 128,
    localparam int DATA_W  = RELOAD_LSB + RELOAD_W,
    localparam int DIV_W   = $clog2(DIV_HI + 1)
) (
    input  logic                clk,
    input  logic                arst_n,
    input  logic                evt_valid,
    input  logic [2:0]          evt_kind,
    input  logic                por_det,
    input  logic                eoi,
    input  logic                wdt_svc,
    input  logic                reg_wr,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic [RELOAD_W-1:0] wdt_reload,
    output logic [DIV_W-1:0]    wdt_div
);

    logic [3:0] cause_flags;
    logic       wdt_flag;
    logic       fsel;
    logic       any_evt;
    logic       wdata_unused;

    assign any_evt      = evt_valid && is_known_kind(evt_kind);
    assign wdata_unused = ^reg_wdata[RELOAD_LSB-1:BIT_FSEL+1];   // R7: ignored bits

    rcf_cause_fsm u_cause (
        .clk         (clk),
        .arst_n      (arst_n),
        .evt_valid   (evt_valid),
        .evt_kind    (evt_kind),
        .por_det     (por_det),
        .eoi         (eoi),
        .cause_flags (cause_flags)
    );

    rcf_wdt_flag u_wdt (
        .clk       (clk),
        .arst_n    (arst_n),
        .evt_valid (evt_valid),
        .evt_kind  (evt_kind),
        .wdt_svc   (wdt_svc),
        .wdt_flag  (wdt_flag)
    );

    rcf_cfg_reg #(
        .RELOAD_W (RELOAD_W),
        .DIV_LO   (DIV_LO),
        .DIV_HI   (DIV_HI)
    ) u_cfg (
        .clk       (clk),
        .arst_n    (arst_n),
        .any_evt   (any_evt),
        .wr        (reg_wr),
        .wr_fsel   (reg_wdata[BIT_FSEL]),
        .wr_reload (reg_wdata[DATA_W-1:RELOAD_LSB]),
        .fsel      (fsel),
        .reload    (wdt_reload),
        .div_ratio (wdt_div)
    );

    always_comb begin
        reg_rdata                           = '0;
        reg_rdata[BIT_FSEL]                 = fsel;
        reg_rdata[BIT_WDT]                  = wdt_flag;
        reg_rdata[BIT_POR:BIT_SW]           = cause_flags;
        reg_rdata[DATA_W-1:RELOAD_LSB]      = wdt_reload;
    end

endmodule

// File: rtl/rcf_flag_reg_chk.sv
module rcf_flag_reg_chk #(
    parameter int RELOAD_W = 8,
    parameter int DIV_LO   = 2,
    parameter int DIV_HI   = 128,
    localparam int DATA_W  = 8 + RELOAD_W,
    localparam int DIV_W   = $clog2(DIV_HI + 1)
) (
    input logic                clk,
    input logic                arst_n,
    input logic                evt_valid,
    input logic [2:0]          evt_kind,
    input logic                por_det,
    input logic                eoi,
    input logic                wdt_svc,
    input logic                reg_wr,
    input logic [DATA_W-1:0]   reg_wdata,
    input logic [DATA_W-1:0]   reg_rdata,
    input logic [RELOAD_W-1:0] wdt_reload,
    input logic [DIV_W-1:0]    wdt_div
);

    logic chk_unused;
    assign chk_unused = por_det ^ (^reg_wdata);

    a_r2_sw_sets: assert property (@(posedge clk) disable iff (!arst_n)
        (evt_valid && evt_kind == 3'd0) |=> reg_rdata[2]);

    a_r3_long_sets: assert property (@(posedge clk) disable iff (!arst_n)
        (evt_valid && evt_kind == 3'd3) |=> (reg_rdata[4:2] == 3'b111));

    a_r4_thermometer: assert property (@(posedge clk) disable iff (!arst_n)
        ((reg_rdata[5:2] & (reg_rdata[5:2] + 4'd1)) == 4'd0));

    a_r5_eoi_clears: assert property (@(posedge clk) disable iff (!arst_n)
        (eoi && !evt_valid) |=> (reg_rdata[5:2] == 4'd0));

    a_r6_wdt_set: assert property (@(posedge clk) disable iff (!arst_n)
        (evt_valid && evt_kind == 3'd1) |=> reg_rdata[1]);

    a_r6_wdt_clear: assert property (@(posedge clk) disable iff (!arst_n)
        (wdt_svc && !(evt_valid && evt_kind == 3'd1)) |=> !reg_rdata[1]);

    a_r7_flags_hold_on_write: assert property (@(posedge clk) disable iff (!arst_n)
        (reg_wr && !evt_valid && !eoi && !wdt_svc) |=> $stable(reg_rdata[7:1]));

    a_r8_div_follows_sel: assert property (@(posedge clk) disable iff (!arst_n)
        (wdt_div == (reg_rdata[0] ? DIV_W'(DIV_HI) : DIV_W'(DIV_LO)))
        && (wdt_reload == reg_rdata[DATA_W-1:8]));

    a_r9_cfg_cleared: assert property (@(posedge clk) disable iff (!arst_n)
        (evt_valid && evt_kind <= 3'd3) |=> (!reg_rdata[0] && reg_rdata[DATA_W-1:8] == '0));

    a_r10_unknown_kind: assert property (@(posedge clk) disable iff (!arst_n)
        (evt_valid && evt_kind >= 3'd4 && !eoi && !wdt_svc && !reg_wr) |=> $stable(reg_rdata));

endmodule

bind rcf_flag_reg rcf_flag_reg_chk #(
    .RELOAD_W (RELOAD_W),
    .DIV_LO   (DIV_LO),
    .DIV_HI   (DIV_HI)
) u_chk (
    .clk        (clk),
    .arst_n     (arst_n),
    .evt_valid  (evt_valid),
    .evt_kind   (evt_kind),
    .por_det    (por_det),
    .eoi        (eoi),
    .wdt_svc    (wdt_svc),
    .reg_wr     (reg_wr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .wdt_reload (wdt_reload),
    .wdt_div    (wdt_div)
);

// File: tb/rcf_flag_reg_bench.sv
`timescale 1ns/1ps
module rcf_flag_reg_bench;

    logic        clk = 1'b0;
    logic        arst_n = 1'b0;
    logic        evt_valid = 1'b0;
    logic [2:0]  evt_kind = 3'd0;
    logic        por_det = 1'b0;
    logic        eoi = 1'b0;
    logic        wdt_svc = 1'b0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic [7:0]  wdt_reload;
    logic [7:0]  wdt_div;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // reference model state
    int       m_sev = 0;
    bit       m_wdt = 1'b0;
    bit       m_fsel = 1'b0;
    bit [7:0] m_reload = 8'd0;

    always #10 clk = ~clk;   // 50 MHz

    rcf_flag_reg u_rcf_flag_reg (
        .clk        (clk),
        .arst_n     (arst_n),
        .evt_valid  (evt_valid),
        .evt_kind   (evt_kind),
        .por_det    (por_det),
        .eoi        (eoi),
        .wdt_svc    (wdt_svc),
        .reg_wr     (reg_wr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .wdt_reload (wdt_reload),
        .wdt_div    (wdt_div)
    );

    function automatic int ev_severity(bit v, bit [2:0] k, bit p);
        if (!v) return 0;
        case (k)
            3'd0: return 1;
            3'd2: return p ? 4 : 2;
            3'd3: return p ? 4 : 3;
            default: return 0;
        endcase
    endfunction

    function automatic bit [15:0] model_word();
        bit [15:0] w;
        w = {m_reload, 8'd0};
        w[0] = m_fsel;
        w[1] = m_wdt;
        w[2] = (m_sev >= 1);
        w[3] = (m_sev >= 2);
        w[4] = (m_sev >= 3);
        w[5] = (m_sev >= 4);
        return w;
    endfunction

    function automatic bit [7:0] model_div();
        return m_fsel ? 8'd128 : 8'd2;
    endfunction

    task automatic model_step();
        int es;
        int base;
        bit any_e;
        bit hw_e;
        es    = ev_severity(evt_valid, evt_kind, por_det);
        any_e = evt_valid && (evt_kind <= 3'd3);
        hw_e  = evt_valid && (evt_kind == 3'd2 || evt_kind == 3'd3);
        base  = eoi ? 0 : m_sev;
        m_sev = (es > base) ? es : base;
        if (evt_valid && evt_kind == 3'd1) m_wdt = 1'b1;
        else if (wdt_svc || hw_e) m_wdt = 1'b0;
        if (any_e) begin
            m_fsel = 1'b0;
            m_reload = 8'd0;
        end else if (reg_wr) begin
            m_fsel = reg_wdata[0];
            m_reload = reg_wdata[15:8];
        end
    endtask

    task automatic check16(string tag, bit [15:0] act, bit [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
        end
    endtask

    // Drive at the falling edge, let the rising edge sample, check 1 ns later.
    task automatic step(string tag, bit v, bit [2:0] k, bit p, bit e, bit s,
                        bit w, bit [15:0] wd);
        evt_valid = v; evt_kind = k; por_det = p; eoi = e; wdt_svc = s;
        reg_wr = w; reg_wdata = wd;
        @(posedge clk);
        model_step();
        #1;
        check16(tag, reg_rdata, model_word());
        check16(tag, {8'd0, wdt_div}, {8'd0, model_div()});
        @(negedge clk);
        evt_valid = 0; eoi = 0; wdt_svc = 0; reg_wr = 0; por_det = 0;
    endtask

    task automatic finish_test();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_test();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        check16("R1", reg_rdata, 16'h0000);
        check16("R1", {8'd0, wdt_div}, 16'd2);
        arst_n = 1'b1;
        @(negedge clk);

        step("R2", 1, 3'd0, 0, 0, 0, 0, 16'h0);
        check16("R2", reg_rdata, 16'h0004);
        step("R5", 0, 3'd0, 0, 1, 0, 0, 16'h0);
        check16("R5", reg_rdata, 16'h0000);
        step("R3", 1, 3'd2, 0, 0, 0, 0, 16'h0);
        check16("R3", reg_rdata, 16'h000C);
        step("R4", 1, 3'd3, 0, 0, 0, 0, 16'h0);
        check16("R4", reg_rdata, 16'h001C);
        step("R4", 1, 3'd0, 0, 0, 0, 0, 16'h0);
        check16("R4", reg_rdata, 16'h001C);
        step("R3", 1, 3'd2, 1, 0, 0, 0, 16'h0);
        check16("R3", reg_rdata, 16'h003C);
        step("R5", 1, 3'd0, 0, 1, 0, 0, 16'h0);
        check16("R5", reg_rdata, 16'h0004);
        step("R6", 1, 3'd1, 0, 0, 0, 0, 16'h0);
        check16("R6", reg_rdata, 16'h0006);
        step("R6", 0, 3'd0, 0, 1, 0, 0, 16'h0);
        check16("R6", reg_rdata, 16'h0002);
        step("R6", 0, 3'd0, 0, 0, 1, 0, 16'h0);
        check16("R6", reg_rdata, 16'h0000);
        step("R6", 1, 3'd1, 0, 0, 1, 0, 16'h0);
        check16("R6", reg_rdata, 16'h0002);
        step("R6", 1, 3'd2, 0, 1, 0, 0, 16'h0);
        check16("R6", reg_rdata, 16'h000C);
        step("R5", 0, 3'd0, 0, 1, 0, 0, 16'h0);
        step("R7", 0, 3'd0, 0, 0, 0, 1, 16'hA5FF);
        check16("R7", reg_rdata, 16'hA501);
        check16("R8", {8'd0, wdt_div}, 16'd128);
        check16("R8", {8'd0, wdt_reload}, 16'h00A5);
        step("R10", 1, 3'd6, 1, 0, 0, 0, 16'h0);
        check16("R10", reg_rdata, 16'hA501);
        step("R9", 1, 3'd1, 0, 0, 0, 1, 16'h3C01);
        check16("R9", reg_rdata, 16'h0002);
        check16("R8", {8'd0, wdt_div}, 16'd2);

        for (int i = 0; i < 1500; i++) begin
            bit v;
            bit [2:0] k;
            v = ($urandom_range(7) == 0);
            k = 3'($urandom_range(7));
            step("R4", v, k, ($urandom_range(3) == 0), ($urandom_range(7) == 0),
                 ($urandom_range(7) == 0), ($urandom_range(5) == 0),
                 16'($urandom));
        end
        finish_test();
    end

endmodule